// File: doc/BRIEF.md
# Sector Program Memory Model

This block models, in synthesizable form, a nonvolatile memory that is rewritten one whole sector at a time. An external agent drives a pin-style bus: active-low chip select, output enable and write enable, a byte address and a byte of write data. The block samples these pins in its own fast clock domain. Bytes written to one sector are collected in a 128-byte staging buffer. The collection window stays open as long as each new load begins within a programmable number of clock cycles after the previous one ended.

When the window times out, the internal cycle runs without further help from the bus. It first sets every byte of the target sector to FFh. It then copies in the bytes that were loaded, so any byte that was not loaded reads FFh. While this runs, reads return status instead of array data. Bit 7 is the inverse of bit 7 of the last byte loaded, and bit 6 alternates from one read to the next. Software can poll either bit to find the end of the cycle.

The bus is a plain pin interface with no valid/ready pair and no back-pressure. Loads that arrive during a cycle are dropped. Whether a load is accepted can be seen only through later reads.

Top module: `sector_flash_model`

## Requirements
- R1: The block drives read data, with `rdata_oe` high, only while `cs_n` and `oe_n` are low and `we_n` is high. Otherwise `rdata_oe` is low and `rdata` is 0.
- R2: A byte load is a strobe during which `cs_n` and `we_n` are both low and `oe_n` is high. The strobe can be formed by pulsing either `we_n` or `cs_n`. The address is taken when the strobe begins and the data when it ends.
- R3: The low `BYTE_AW` address bits (bits 6:0 by default) pick the byte and the upper `SECT_AW` bits pick the sector. Bytes may be loaded in any order. If a byte is loaded more than once in a window, its last value is kept.
- R4: A load that begins within `WIN_CYC` cycles of the end of the previous accepted load joins the same window. When `WIN_CYC` cycles pass with no accepted load, the program cycle starts.
- R5: After the cycle, every byte of the target sector that was not loaded reads FFh. Other sectors are unchanged.
- R6: During the cycle, a read at any address returns bit 7 equal to the inverse of bit 7 of the last byte loaded, with bits 5:0 zero.
- R7: During the cycle, bit 6 of the status is 0 on the first read and flips after each completed read. Once the cycle ends, repeated reads return the same array data.
- R8: After the cycle, reads return the programmed array contents.
- R9: The first load of a window fixes the sector. A later load in that window to a different sector is dropped and sets `sector_err`, which stays set until reset.
- R10: A load that begins while a cycle is running is dropped. It sets no error and does not start another cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | SECT_AW+BYTE_AW | Byte address; upper bits are the sector |
| wdata | input | 8 | Byte to load |
| rdata | output | 8 | Read data or busy status |
| rdata_oe | output | 1 | High when `rdata` should be driven onto a shared bus |
| sector_err | output | 1 | Sticky flag for a dropped sector-mismatch load |

## Verification
The assertions rely on a well-formed bus. The address and write data must be steady for at least the synchronizer depth around each strobe edge. Read and load strobes must never overlap, and each strobe phase must last several clocks so that no edge is lost in sampling. The stimulus meets these conditions by setting the address and data before it lowers any control line. It holds every control phase for at least three clocks and returns `cs_n` high between transactions. Each load begins about a dozen cycles after the previous one, well inside the window, except for one deliberate pause of half the window.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ERASE_WR,
    SQ_ERASE_WAIT,
    SQ_PROG_WR,
    SQ_PROG_WAIT
  } seq_state_e;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;
endpackage

// File: rtl/sfm_bus_sync.sv
module sfm_bus_sync #(
  parameter int AW     = 10,
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ld_start,
  output logic          ld_end,
  output logic          rd_act,
  output logic          rd_end,
  output logic [AW-1:0] addr_s,
  output logic [DW-1:0] data_s
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] cs_sr, oe_sr, we_sr;
  logic [AW-1:0]     addr_sr [STAGES];
  logic [DW-1:0]     data_sr [STAGES];
  logic              wr_lvl, rd_lvl, wr_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr <= '1;
      oe_sr <= '1;
      we_sr <= '1;
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      for (int k = 0; k < STAGES; k++) begin
        addr_sr[k] <= '0;
        data_sr[k] <= '0;
      end
    end else begin
      cs_sr[0]   <= cs_n;
      oe_sr[0]   <= oe_n;
      we_sr[0]   <= we_n;
      addr_sr[0] <= addr;
      data_sr[0] <= wdata;
      for (int k = 1; k < STAGES; k++) begin
        cs_sr[k]   <= cs_sr[k-1];
        oe_sr[k]   <= oe_sr[k-1];
        we_sr[k]   <= we_sr[k-1];
        addr_sr[k] <= addr_sr[k-1];
        data_sr[k] <= data_sr[k-1];
      end
      wr_q <= wr_lvl;
      rd_q <= rd_lvl;
    end
  end

  assign wr_lvl   = ~cs_sr[LAST] & ~we_sr[LAST] & oe_sr[LAST];
  assign rd_lvl   = ~cs_sr[LAST] & ~oe_sr[LAST] & we_sr[LAST];
  assign ld_start = wr_lvl & ~wr_q;
  assign ld_end   = ~wr_lvl & wr_q;
  assign rd_act   = rd_lvl;
  assign rd_end   = ~rd_lvl & rd_q;
  assign addr_s   = addr_sr[LAST];
  assign data_s   = data_sr[LAST];
endmodule

// File: rtl/sfm_loader.sv
module sfm_loader #(
  parameter int SAW     = 3,
  parameter int BAW     = 7,
  parameter int DW      = 8,
  parameter int WIN_CYC = 200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_start,
  input  logic               ld_end,
  input  logic [SAW+BAW-1:0] ld_addr,
  input  logic [DW-1:0]      ld_data,
  input  logic               busy_i,
  input  logic [BAW-1:0]     buf_idx,
  output logic               go,
  output logic [SAW-1:0]     sect,
  output logic [DW-1:0]      last_data,
  output logic [DW-1:0]      buf_byte,
  output logic               buf_vld,
  output logic               err
);
  localparam int NB = 1 << BAW;
  localparam int TW = $clog2(WIN_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(WIN_CYC - 1);

  logic [DW-1:0]  buf_mem [NB];
  logic [NB-1:0]  mask;
  logic           win_open, in_load;
  logic [SAW-1:0] sect_q;
  logic [BAW-1:0] idx_q;
  logic [TW-1:0]  timer;
  logic [SAW-1:0] ld_sect;
  logic [BAW-1:0] ld_byte;
  logic           take_new, take_more, reject, expire;

  assign ld_sect   = ld_addr[SAW+BAW-1:BAW];
  assign ld_byte   = ld_addr[BAW-1:0];
  assign take_new  = ld_start && !busy_i && !win_open;
  assign take_more = ld_start && !busy_i && win_open && (ld_sect == sect_q);
  assign reject    = ld_start && !busy_i && win_open && (ld_sect != sect_q);
  assign expire    = win_open && !in_load && !ld_start && (timer == T_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open  <= 1'b0;
      in_load   <= 1'b0;
      sect_q    <= '0;
      idx_q     <= '0;
      timer     <= '0;
      mask      <= '0;
      last_data <= '0;
      err       <= 1'b0;
      go        <= 1'b0;
    end else begin
      go <= expire;
      if (win_open && !in_load && !ld_start) begin
        if (expire) begin
          win_open <= 1'b0;
          timer    <= '0;
        end else begin
          timer <= timer + 1'b1;
        end
      end
      if (take_new) begin
        win_open <= 1'b1;
        sect_q   <= ld_sect;
        mask     <= '0;
      end
      if (take_new || take_more) begin
        in_load <= 1'b1;
        idx_q   <= ld_byte;
        timer   <= '0;
      end
      if (reject) err <= 1'b1;
      if (ld_end && in_load) begin
        mask[idx_q] <= 1'b1;
        last_data   <= ld_data;
        in_load     <= 1'b0;
        timer       <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ld_end && in_load) buf_mem[idx_q] <= ld_data;
  end

  assign buf_byte = buf_mem[buf_idx];
  assign buf_vld  = mask[buf_idx];
  assign sect     = sect_q;

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R10
  busy_load_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && ld_start) |=> !in_load);

  // R4
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer <= T_LAST);
endmodule

// File: rtl/sfm_sequencer.sv
module sfm_sequencer
  import sfm_pkg::*;
#(
  parameter int SAW       = 3,
  parameter int BAW       = 7,
  parameter int DW        = 8,
  parameter int ERASE_CYC = 40,
  parameter int PROG_CYC  = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [SAW-1:0]     sect_i,
  input  logic [DW-1:0]      buf_byte,
  input  logic               buf_vld,
  output logic               busy,
  output logic [BAW-1:0]     buf_idx,
  output logic               wr_en,
  output logic [SAW+BAW-1:0] wr_addr,
  output logic [DW-1:0]      wr_data
);
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] E_LAST = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] P_LAST = CW'(PROG_CYC - 1);

  seq_state_e     st;
  logic [BAW-1:0] idx;
  logic [SAW-1:0] sect_q;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      idx    <= '0;
      sect_q <= '0;
      cnt    <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (go) begin
          st     <= SQ_ERASE_WR;
          idx    <= '0;
          sect_q <= sect_i;
        end
        SQ_ERASE_WR: begin
          idx <= idx + 1'b1;
          if (idx == '1) begin
            st  <= SQ_ERASE_WAIT;
            cnt <= '0;
          end
        end
        SQ_ERASE_WAIT: begin
          if (cnt == E_LAST) begin
            st  <= SQ_PROG_WR;
            idx <= '0;
          end else cnt <= cnt + 1'b1;
        end
        SQ_PROG_WR: begin
          idx <= idx + 1'b1;
          if (idx == '1) begin
            st  <= SQ_PROG_WAIT;
            cnt <= '0;
          end
        end
        SQ_PROG_WAIT: begin
          if (cnt == P_LAST) st <= SQ_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy    = (st != SQ_IDLE);
  assign buf_idx = idx;
  assign wr_addr = {sect_q, idx};
  assign wr_en   = (st == SQ_ERASE_WR) || ((st == SQ_PROG_WR) && buf_vld);
  assign wr_data = (st == SQ_ERASE_WR) ? DW'(BLANK_BYTE) : buf_byte;

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !go);
endmodule

// File: rtl/sfm_array.sv
module sfm_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  // R5
  write_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy_i);
endmodule

// File: rtl/sector_flash_model.sv
module sector_flash_model #(
  parameter int SECT_AW     = 3,
  parameter int BYTE_AW     = 7,
  parameter int WIN_CYC     = 200,
  parameter int ERASE_CYC   = 40,
  parameter int PROG_CYC    = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       oe_n,
  input  logic                       we_n,
  input  logic [SECT_AW+BYTE_AW-1:0] addr,
  input  logic [7:0]                 wdata,
  output logic [7:0]                 rdata,
  output logic                       rdata_oe,
  output logic                       sector_err
);
  localparam int AW = SECT_AW + BYTE_AW;
  localparam int DW = 8;

  logic          ld_start, ld_end, rd_act, rd_end;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] data_s;
  logic          go, busy, buf_vld, wr_en;
  logic [SECT_AW-1:0] sect;
  logic [DW-1:0] last_data, buf_byte, wr_data, mem_q;
  logic [BYTE_AW-1:0] buf_idx;
  logic [AW-1:0] wr_addr;
  logic          tog;
  logic [DW-1:0] rdata_q;
  logic          oe_q;

  sfm_bus_sync #(.AW(AW), .DW(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .ld_start(ld_start), .ld_end(ld_end),
    .rd_act(rd_act), .rd_end(rd_end), .addr_s(addr_s), .data_s(data_s)
  );

  sfm_loader #(.SAW(SECT_AW), .BAW(BYTE_AW), .DW(DW), .WIN_CYC(WIN_CYC)) u_load (
    .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_end(ld_end),
    .ld_addr(addr_s), .ld_data(data_s), .busy_i(busy), .buf_idx(buf_idx),
    .go(go), .sect(sect), .last_data(last_data), .buf_byte(buf_byte),
    .buf_vld(buf_vld), .err(sector_err)
  );

  sfm_sequencer #(.SAW(SECT_AW), .BAW(BYTE_AW), .DW(DW),
                  .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .sect_i(sect), .buf_byte(buf_byte),
    .buf_vld(buf_vld), .busy(busy), .buf_idx(buf_idx), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  sfm_array #(.AW(AW), .DW(DW)) u_arr (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(addr_s), .rd_data(mem_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog     <= 1'b0;
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= rd_act;
      if (go) tog <= 1'b0;
      else if (busy && rd_end) tog <= ~tog;
      if (!rd_act) rdata_q <= '0;
      else if (busy) rdata_q <= {~last_data[DW-1], tog, {(DW-2){1'b0}}};
      else rdata_q <= mem_q;
    end
  end

  assign rdata    = rdata_q;
  assign rdata_oe = oe_q;

  // R1
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |=> (!rdata_oe && rdata == '0));
endmodule

// File: tb/sector_flash_model_tb_top.sv
module sector_flash_model_tb_top;
  localparam int SAW = 3, BAW = 7, AW = SAW + BAW;
  localparam int WIN = 200, ER = 40, PR = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic rdata_oe, sector_err;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sector_flash_model #(.SECT_AW(SAW), .BYTE_AW(BAW), .WIN_CYC(WIN),
                       .ERASE_CYC(ER), .PROG_CYC(PR)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .sector_err(sector_err)
  );

  function automatic logic [7:0] pat_a(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] pat_b(int i);
    return 8'((i * 11 + 128) & 255);
  endfunction

  function automatic logic [AW-1:0] mk(int s, int b);
    return {SAW'(s), BAW'(b)};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_we(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; oe_n = 1'b1; cs_n = 1'b0;
    idle(3); we_n = 1'b0;
    idle(4); we_n = 1'b1;
    idle(3); cs_n = 1'b1;
    idle(2);
  endtask

  task automatic load_ce(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; oe_n = 1'b1; we_n = 1'b0;
    idle(3); cs_n = 1'b0;
    idle(4); cs_n = 1'b1;
    idle(3); we_n = 1'b1;
    idle(2);
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; we_n = 1'b1; oe_n = 1'b0; cs_n = 1'b0;
    idle(8);
    d = rdata; oe = rdata_oe;
    oe_n = 1'b1; cs_n = 1'b1;
    idle(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, e;
    logic oe;
    idle(10);
    rst_n = 1'b1;
    idle(3);
    check("R1", {7'd0, rdata_oe}, 8'd0, "oe after reset");
    check("R1", rdata, 8'd0, "data after reset");
    check("R9", {7'd0, sector_err}, 8'd0, "err after reset");
    cs_n = 1'b0;
    idle(8);
    check("R1", {7'd0, rdata_oe}, 8'd0, "oe with cs only");
    cs_n = 1'b1;
    idle(4);

    // Sector 2: full reverse-order load via write-enable strobes
    for (int i = 127; i >= 0; i--) load_we(mk(2, i), pat_a(i));
    idle(WIN + 30 + 500);
    for (int i = 0; i < 128; i++) begin
      rd(mk(2, i), d, oe);
      check("R3", d, pat_a(i), "sector2 reverse order byte");
      if (i == 0) check("R1", {7'd0, oe}, 8'd1, "oe during read");
    end
    idle(4);
    check("R1", {7'd0, rdata_oe}, 8'd0, "oe after read");

    // Sector 5: sparse load via chip-select strobes, with a mid-window pause
    for (int i = 0; i < 128; i += 3) begin
      load_ce(mk(5, i), pat_b(i));
      if (i == 60) idle(WIN / 2);
    end
    load_ce(mk(5, 3), 8'h22);
    idle(WIN + 30 + 500);
    for (int i = 0; i < 128; i++) begin
      rd(mk(5, i), d, oe);
      if (i == 3) check("R3", d, 8'h22, "reloaded byte keeps last value");
      else if (i % 3 == 0 && i <= 60) check("R4", d, pat_b(i), "byte before pause");
      else if (i % 3 == 0) check("R2", d, pat_b(i), "chip-select strobe load");
      else check("R5", d, 8'hFF, "unloaded byte blank");
    end
    for (int i = 0; i < 128; i++) begin
      rd(mk(2, i), d, oe);
      check("R5", d, pat_a(i), "other sector unchanged");
    end

    // Sector 4: busy status polling and a load during the cycle
    load_we(mk(4, 7), 8'hC3);
    idle(WIN + 30);
    for (int k = 0; k < 3; k++) begin
      rd(mk(0, k), d, oe);
      check("R6", {d[7], 7'd0}, 8'h00, "status bit7 inverted");
      check("R6", {2'd0, d[5:0]}, 8'h00, "status low bits zero");
      e = (k % 2 == 1) ? 8'h40 : 8'h00;
      check("R7", {1'b0, d[6], 6'd0}, e, "status bit6 toggle");
    end
    load_we(mk(5, 1), 8'h12);
    idle(600);
    check("R10", {7'd0, sector_err}, 8'd0, "busy load sets no error");
    rd(mk(4, 7), d, oe);
    check("R8", d, 8'hC3, "true data after cycle");
    rd(mk(4, 7), d, oe);
    check("R7", d, 8'hC3, "no toggling after cycle");
    rd(mk(4, 8), d, oe);
    check("R5", d, 8'hFF, "unloaded sector4 byte");
    rd(mk(5, 1), d, oe);
    check("R10", d, 8'hFF, "busy load dropped");

    // Sector 1 window with a stray load to sector 2
    load_we(mk(1, 10), 8'h3C);
    load_we(mk(2, 0), 8'h99);
    check("R9", {7'd0, sector_err}, 8'd1, "mismatch sets error");
    idle(WIN + 30 + 500);
    check("R9", {7'd0, sector_err}, 8'd1, "error sticky");
    rd(mk(1, 10), d, oe);
    check("R9", d, 8'h3C, "window sector programmed");
    rd(mk(1, 11), d, oe);
    check("R5", d, 8'hFF, "sector1 unloaded byte");
    rd(mk(2, 0), d, oe);
    check("R9", d, pat_a(0), "mismatched load dropped");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule